// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch engine and a display pipeline. It takes 32-bit words read from memory and expands each one into one or two pixels. Each pixel has three 8-bit components. A 4-bit format code, sampled together with each word, selects how that word is decoded. Six RGB encodings are supported: three 16-bit encodings, one 24-bit encoding and two 32-bit encodings. There is also one packed 4:2:2 luma/chroma encoding, in which two luma samples share a single Cb/Cr pair. For that encoding, a 2-bit ordering code says where each byte sits in the word.

Both the word input and the pixel output use a valid/ready handshake. A new word is taken only once the last pixel of the previous word is leaving the block. With every pixel the block presents a flag saying whether the components are Y/Cb/Cr or R/G/B. A later colour converter uses that flag to decide between converting and passing the pixel through. An unrecognised format code produces black pixels and sets a sticky error flag.

Top module: `pxu_top`

## Requirements
- R1: Format code 0x4 is RGB565. Each halfword holds one pixel: R in bits [15:11], G in [10:5], B in [4:0]. The lower halfword is output first, then the upper halfword.
- R2: Format code 0x5 is a 16-bit encoding with a 1-bit alpha. Each halfword holds R in [14:10], G in [9:5] and B in [4:0]. Bit 15 of each halfword is ignored. The lower halfword is output first.
- R3: Format code 0x6 is a 16-bit encoding with a 4-bit alpha. Each halfword holds R in [11:8], G in [7:4] and B in [3:0]. Bits [15:12] of each halfword are ignored. The lower halfword is output first.
- R4: Format code 0x8 is 24-bit RGB, one pixel per word. R is in [23:16], G in [15:8] and B in [7:0]. Bits [31:24] are ignored.
- R5: Format code 0x9 gives one pixel per word, with R in [23:16], G in [15:8] and B in [7:0]. Format code 0xA is the same except that R is in [7:0] and B is in [23:16]. For both codes, bits [31:24] are ignored.
- R6: Format code 0x7 gives two pixels per word: Y1 first, then Y2. Both pixels carry the same Cb and Cr. The ordering code gives the bytes from most to least significant, as follows.
  - 0: Y2, Cr, Y1, Cb
  - 1: Y2, Cb, Y1, Cr
  - 2: Cr, Y2, Cb, Y1
  - 3: Cb, Y2, Cr, Y1
- R7: `out_is_ycc` is 1 for pixels from a word with code 0x7, and 0 for pixels from any other code.
- R8: Components narrower than 8 bits are widened by appending their own most significant bits below them. A 5-bit value v becomes {v, v[4:2]}, a 6-bit value becomes {v, v[5:4]}, and a 4-bit value becomes {v, v}. All-ones therefore maps to 0xFF.
- R9: A word with any code outside 0x4 to 0xA produces one pixel of value 0. It also sets `fmt_err` from the next cycle onwards, and `fmt_err` stays set until reset.
- R10: `in_ready` is 1 in exactly two cases: no pixel is pending, or the last pending pixel of the current word is being accepted downstream in the same cycle. While `out_valid` is 1 and `out_ready` is 0, the output pixel and the flag do not change.
- R11: A word accepted at a clock edge presents its first pixel from that edge onwards. After reset, `out_valid` and `fmt_err` are 0 and `in_ready` is 1.
- R12: Output pixels are packed as {c0, c1, c2} in bits [23:16], [15:8] and [7:0]. c0, c1, c2 are R, G, B for the RGB codes, and Y, Cb, Cr for code 0x7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_code | input | 4 | Format of the word on `in_word`, sampled with it |
| yc_order | input | 2 | Byte ordering for the 4:2:2 format, sampled with the word |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | A pixel is presented |
| out_ready | input | 1 | The downstream stage takes the pixel |
| out_pixel | output | 24 | Pixel {c0, c1, c2} |
| out_is_ycc | output | 1 | The pixel holds Y/Cb/Cr rather than R/G/B |
| fmt_err | output | 1 | Sticky flag: an unknown format code was seen |

## Verification
Each format is driven with words whose fields are all-ones, all-zero or mixed. This separates the lower halfword from the upper one and shows whether the widening fills the low bits. It also exposes a swapped red/blue field. For the luma/chroma format, one word with four distinct byte values is sent under every ordering code, so any mix-up of luma and chroma positions shows at once. Alpha and padding bits are set to both ones and zeros to show that they have no effect. A long run of pseudo-random words, with format codes and back-pressure patterns mixed together, exercises the stall and the accept-on-last-pixel handshake rule.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int COMP_W = 8;
  localparam int PIX_W  = 3 * COMP_W;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [3:0] {
    FMT_RGB565 = 4'h4,
    FMT_X1555  = 4'h5,
    FMT_X4444  = 4'h6,
    FMT_YC422  = 4'h7,
    FMT_RGB888 = 4'h8,
    FMT_XRGB32 = 4'h9,
    FMT_XBGR32 = 4'hA
  } pxu_fmt_e;
endpackage

// File: rtl/pxu_widen.sv
module pxu_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  // Bit replication: output bit counted from the top takes input bit (i mod IN_W) from the top.
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign dout[OUT_W-1-i] = din[IN_W-1-(i % IN_W)];
  end
endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [3:0]        fmt,
  input  logic [1:0]        order,
  output logic [PIX_W-1:0]  pix0,
  output logic [PIX_W-1:0]  pix1,
  output logic              two_pix,
  output logic              known,
  output logic              is_ycc
);
  localparam int NHALF = 2;

  logic [PIX_W-1:0] p565  [NHALF];
  logic [PIX_W-1:0] p1555 [NHALF];
  logic [PIX_W-1:0] p4444 [NHALF];

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int B = h * HALF_W;
    logic [COMP_W-1:0] r565, g565, b565, r15, g15, b15, r12, g12, b12;
    pxu_widen #(.IN_W(5), .OUT_W(COMP_W)) u_r565 (.din(word[B+11 +: 5]), .dout(r565));
    pxu_widen #(.IN_W(6), .OUT_W(COMP_W)) u_g565 (.din(word[B+5  +: 6]), .dout(g565));
    pxu_widen #(.IN_W(5), .OUT_W(COMP_W)) u_b565 (.din(word[B    +: 5]), .dout(b565));
    pxu_widen #(.IN_W(5), .OUT_W(COMP_W)) u_r15  (.din(word[B+10 +: 5]), .dout(r15));
    pxu_widen #(.IN_W(5), .OUT_W(COMP_W)) u_g15  (.din(word[B+5  +: 5]), .dout(g15));
    pxu_widen #(.IN_W(5), .OUT_W(COMP_W)) u_b15  (.din(word[B    +: 5]), .dout(b15));
    pxu_widen #(.IN_W(4), .OUT_W(COMP_W)) u_r12  (.din(word[B+8  +: 4]), .dout(r12));
    pxu_widen #(.IN_W(4), .OUT_W(COMP_W)) u_g12  (.din(word[B+4  +: 4]), .dout(g12));
    pxu_widen #(.IN_W(4), .OUT_W(COMP_W)) u_b12  (.din(word[B    +: 4]), .dout(b12));
    assign p565[h]  = {r565, g565, b565};
    assign p1555[h] = {r15, g15, b15};
    assign p4444[h] = {r12, g12, b12};
  end

  logic [COMP_W-1:0] yb3, yb2, yb1, yb0;
  logic [COMP_W-1:0] y1, y2, cb, cr;

  assign {yb3, yb2, yb1, yb0} = word;

  always_comb begin
    case (order)
      2'd0:    begin y2 = yb3; cr = yb2; y1 = yb1; cb = yb0; end
      2'd1:    begin y2 = yb3; cb = yb2; y1 = yb1; cr = yb0; end
      2'd2:    begin cr = yb3; y2 = yb2; cb = yb1; y1 = yb0; end
      default: begin cb = yb3; y2 = yb2; cr = yb1; y1 = yb0; end
    endcase
  end

  always_comb begin
    pix0    = '0;
    pix1    = '0;
    two_pix = 1'b0;
    known   = 1'b1;
    is_ycc  = 1'b0;
    case (fmt)
      FMT_RGB565: begin pix0 = p565[0];  pix1 = p565[1];  two_pix = 1'b1; end
      FMT_X1555:  begin pix0 = p1555[0]; pix1 = p1555[1]; two_pix = 1'b1; end
      FMT_X4444:  begin pix0 = p4444[0]; pix1 = p4444[1]; two_pix = 1'b1; end
      FMT_YC422:  begin
        pix0    = {y1, cb, cr};
        pix1    = {y2, cb, cr};
        two_pix = 1'b1;
        is_ycc  = 1'b1;
      end
      FMT_RGB888, FMT_XRGB32: pix0 = {yb2, yb1, yb0};
      FMT_XBGR32:             pix0 = {yb0, yb1, yb2};
      default:                known = 1'b0;
    endcase
  end
endmodule

// File: rtl/pxu_stage.sv
module pxu_stage
  import pxu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] pix0_in,
  input  logic [PIX_W-1:0] pix1_in,
  input  logic             two_in,
  input  logic             ycc_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_ycc,
  output logic             on_last
);
  logic             hold_q, hold_d;
  logic             sel_q, sel_d;
  logic             two_q, ycc_q;
  logic [PIX_W-1:0] p0_q, p1_q;
  logic             advance;

  assign advance = hold_q & out_ready;
  assign on_last = ~two_q | sel_q;

  always_comb begin
    hold_d = hold_q;
    sel_d  = sel_q;
    if (load) begin
      hold_d = 1'b1;
      sel_d  = 1'b0;
    end else if (advance) begin
      if (on_last) hold_d = 1'b0;
      else         sel_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q  <= '0;
      p1_q  <= '0;
      two_q <= 1'b0;
      ycc_q <= 1'b0;
    end else if (load) begin
      p0_q  <= pix0_in;
      p1_q  <= pix1_in;
      two_q <= two_in;
      ycc_q <= ycc_in;
    end
  end

  assign out_valid = hold_q;
  assign out_pix   = sel_q ? p1_q : p0_q;
  assign out_ycc   = ycc_q;

  // R10: a stalled pixel stays put
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !out_ready |=> hold_q && $stable(out_pix) && $stable(ycc_q));
endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fmt_code,
  input  logic [1:0]        yc_order,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              out_is_ycc,
  output logic              fmt_err
);
  logic [PIX_W-1:0] dec_p0, dec_p1;
  logic             dec_two, dec_known, dec_ycc;
  logic             load, on_last;
  logic             err_q, err_d;

  pxu_decode u_dec (
    .word(in_word), .fmt(fmt_code), .order(yc_order),
    .pix0(dec_p0), .pix1(dec_p1), .two_pix(dec_two),
    .known(dec_known), .is_ycc(dec_ycc)
  );

  assign in_ready = ~out_valid | (out_ready & on_last);
  assign load     = in_valid & in_ready;

  pxu_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load(load),
    .pix0_in(dec_p0), .pix1_in(dec_p1), .two_in(dec_two), .ycc_in(dec_ycc),
    .out_ready(out_ready), .out_valid(out_valid), .out_pix(out_pixel),
    .out_ycc(out_is_ycc), .on_last(on_last)
  );

  assign err_d = err_q | (load & ~dec_known);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign fmt_err = err_q;

  // R11: an accepted word shows a pixel at the next edge
  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: the error flag never clears without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  // R9: the pixel that raised the flag is black
  a_r9_black_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $rose(fmt_err) |-> out_pixel == '0);

  // R6: second pixel of a luma/chroma word keeps the chroma pair
  a_r6_shared_chroma: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_ycc && out_ready && !on_last |=>
      out_valid && out_pixel[2*COMP_W-1:0] == $past(out_pixel[2*COMP_W-1:0]));

  // R10: no word is taken while a non-final pixel is pending
  a_r10_no_early_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !on_last |-> !in_ready);
endmodule

// File: tb/pxu_top_test.sv
module pxu_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fmt_code;
  logic [1:0]  yc_order;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_pixel;
  logic        out_is_ycc;
  logic        fmt_err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [24:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit          rand_ready = 0;
  bit          acc;

  always #10 clk = ~clk;

  pxu_top uut (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .yc_order(yc_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_is_ycc(out_is_ycc), .fmt_err(fmt_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wid(int v, int n);
    if (n == 4) return v * 17;
    if (n == 5) return ((v << 3) | (v >> 2)) & 255;
    return ((v << 2) | (v >> 4)) & 255;
  endfunction

  function automatic logic [24:0] rgb(int r, int g, int b);
    return {1'b0, r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic ref_push(logic [31:0] w, logic [3:0] f, logic [1:0] o);
    int hw, y1, y2, cb, cr;
    int by[4];
    for (int i = 0; i < 4; i++) by[i] = (w >> (8 * i)) & 255;
    case (f)
      4'h4, 4'h5, 4'h6:
        for (int h = 0; h < 2; h++) begin
          hw = (w >> (16 * h)) & 16'hFFFF;
          if (f == 4'h4)
            exp_q.push_back(rgb(wid((hw >> 11) & 31, 5), wid((hw >> 5) & 63, 6), wid(hw & 31, 5)));
          else if (f == 4'h5)
            exp_q.push_back(rgb(wid((hw >> 10) & 31, 5), wid((hw >> 5) & 31, 5), wid(hw & 31, 5)));
          else
            exp_q.push_back(rgb(wid((hw >> 8) & 15, 4), wid((hw >> 4) & 15, 4), wid(hw & 15, 4)));
        end
      4'h7: begin
        case (o)
          2'd0: begin y2 = by[3]; cr = by[2]; y1 = by[1]; cb = by[0]; end
          2'd1: begin y2 = by[3]; cb = by[2]; y1 = by[1]; cr = by[0]; end
          2'd2: begin cr = by[3]; y2 = by[2]; cb = by[1]; y1 = by[0]; end
          default: begin cb = by[3]; y2 = by[2]; cr = by[1]; y1 = by[0]; end
        endcase
        exp_q.push_back({1'b1, y1[7:0], cb[7:0], cr[7:0]});
        exp_q.push_back({1'b1, y2[7:0], cb[7:0], cr[7:0]});
      end
      4'h8, 4'h9: exp_q.push_back(rgb(by[2], by[1], by[0]));
      4'hA:       exp_q.push_back(rgb(by[0], by[1], by[2]));
      default:    exp_q.push_back(25'h0);
    endcase
  endtask

  // One clock: drive at the falling edge, evaluate the handshakes, model the rising edge.
  task automatic tick(bit v, logic [31:0] w, logic [3:0] f, logic [1:0] o);
    logic [24:0] front;
    bit exp_rdy;
    @(negedge clk);
    in_valid  = v;
    in_word   = w;
    fmt_code  = f;
    yc_order  = o;
    out_ready = rand_ready ? lfsr[0] : 1'b1;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready);
    chk("R10 in_ready", {31'b0, in_ready}, {31'b0, exp_rdy});
    chk("R11 out_valid", {31'b0, out_valid}, {31'b0, exp_q.size() != 0});
    if (out_valid && out_ready && exp_q.size() != 0) begin
      front = exp_q.pop_front();
      chk("R12 pixel", {8'b0, out_pixel}, {8'b0, front[23:0]});
      chk("R7 ycc flag", {31'b0, out_is_ycc}, {31'b0, front[24]});
    end
    acc = v && in_ready;
    if (acc) ref_push(w, f, o);
  endtask

  task automatic send(logic [31:0] w, logic [3:0] f, logic [1:0] o);
    do tick(1'b1, w, f, o); while (!acc);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) tick(1'b0, 32'h0, 4'h0, 2'd0);
    chk("R10 drained", exp_q.size(), 0);
  endtask

  // Direct check of the first pixel of one word, with the output held stalled.
  task automatic peek(string req, logic [31:0] w, logic [3:0] f, logic [1:0] o, logic [23:0] exp_px);
    rand_ready = 0;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; fmt_code = f; yc_order = o; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {8'b0, out_pixel}, {8'b0, exp_px});
    @(negedge clk);
    chk("R10 stalled hold", {8'b0, out_pixel}, {8'b0, exp_px});
    chk("R10 no take while stalled", {31'b0, in_ready}, 32'd0);
    out_ready = 1'b1;
    for (int i = 0; i < 4 && out_valid; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; fmt_code = '0; yc_order = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 reset err", {31'b0, fmt_err}, 32'd0);
    chk("R11 reset in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // Directed first-pixel checks
    peek("R1 565 low half first", 32'hF800_07E0, 4'h4, 2'd0, 24'h00FF00);
    peek("R8 565 widen 0x10", 32'h0000_8000, 4'h4, 2'd0, 24'h840000);
    peek("R2 1555 alpha ignored", 32'h0000_FFFF, 4'h5, 2'd0, 24'hFFFFFF);
    peek("R2 1555 alpha ignored 0", 32'h0000_8000, 4'h5, 2'd0, 24'h000000);
    peek("R3 4444 alpha ignored", 32'h0000_F123, 4'h6, 2'd0, 24'h112233);
    peek("R4 888 top byte ignored", 32'hAB12_3456, 4'h8, 2'd0, 24'h123456);
    peek("R5 xrgb", 32'hFF12_3456, 4'h9, 2'd0, 24'h123456);
    peek("R5 xbgr swap", 32'h0012_3456, 4'hA, 2'd0, 24'h563412);
    peek("R6 order0", 32'h1122_3344, 4'h7, 2'd0, 24'h334422);
    peek("R6 order1", 32'h1122_3344, 4'h7, 2'd1, 24'h332244);
    peek("R6 order2", 32'h1122_3344, 4'h7, 2'd2, 24'h443311);
    peek("R6 order3", 32'h1122_3344, 4'h7, 2'd3, 24'h441133);
    chk("R9 no err yet", {31'b0, fmt_err}, 32'd0);

    // Streamed with the model: every format, both halves, all orders
    rand_ready = 0;
    send(32'hF800_07E0, 4'h4, 2'd0);
    send(32'h7C00_83E0, 4'h5, 2'd0);
    send(32'hAF00_50F0, 4'h6, 2'd0);
    for (int o = 0; o < 4; o++) send(32'h1122_3344, 4'h7, o[1:0]);
    send(32'hAB12_3456, 4'h8, 2'd0);
    send(32'h0012_3456, 4'h9, 2'd0);
    send(32'h00AA_BBCC, 4'hA, 2'd0);
    drain();

    // R9: unknown code
    send(32'hFFFF_FFFF, 4'h3, 2'd0);
    drain();
    chk("R9 err set", {31'b0, fmt_err}, 32'd1);
    send(32'h1234_5678, 4'h9, 2'd0);
    send(32'hDEAD_BEEF, 4'hF, 2'd0);
    drain();
    chk("R9 err sticky", {31'b0, fmt_err}, 32'd1);

    // Pseudo-random words and back-pressure
    rand_ready = 1;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      w = {lfsr, lfsr ^ 16'h5A3C} ^ (n * 32'h9E37_79B9);
      send(w, 4'(4 + (n % 8)), 2'(n / 8));
    end
    rand_ready = 0;
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule